// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the state of a bank of interrupt sources and turns their activity into presentation requests. Each source is fixed at build time as either edge-style (a rising edge on its line is one message event) or level-style (the line is held while service is needed). For every source the block keeps a target server, a priority, a saved priority and a small set of status flags: masked-while-pending, rejected, asserted and already-sent. A priority of all ones (0xFF) means the source is masked.

Requests go out on a channel carrying the server, the global source number (local index plus a base offset parameter, default 0x1000) and the priority. The presentation side answers with reject and end-of-interrupt notifications, identified by global number, and with a resend broadcast. A resend starts a scan that visits one source per clock. Requests owed by several sources at once are issued one per clock, lowest index first.

Top module: `intr_source_ctl`

## Requirements
- R1: A source whose priority is 0xFF issues no request: an edge on an edge-style source records masked-pending instead, and an asserted level-style source waits.
- R2: A rising edge on an unmasked edge-style source issues one request carrying its server, its global number (BASE plus index, BASE default 0x1000) and its priority.
- R3: A configuration write that gives an unmasked priority to an edge-style source with masked-pending set clears that flag and issues one request.
- R4: A level-style source that is unmasked, asserted and not yet sent issues one request when its line changes and marks itself sent; while sent it issues no further request.
- R5: A reject naming a source sets the rejected flag on an edge-style source and clears the sent flag on a level-style source.
- R6: A resend broadcast revisits every source: a rejected edge-style source clears the flag and, if unmasked, issues a request again; an edge-style source that was not rejected issues nothing; a level-style source repeats its unmasked, asserted and not-sent check.
- R7: An end-of-interrupt clears the sent flag of a level-style source, which requests again on the next resend if still asserted; it has no effect on an edge-style source.
- R8: Reject and end-of-interrupt numbers below BASE or at or above BASE plus the source count are ignored.
- R9: Requests owed by several sources in the same cycle are issued one per clock in ascending index order.
- R10: Reset clears every status flag and sets every priority and saved priority to 0xFF; the server field returns to zero and the source type is kept.
- R11: A configuration write replaces server, priority and saved priority; on a level-style source it runs the unmasked, asserted and not-sent check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Per-source interrupt lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index of the source being written |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | 8 | New priority (0xFF masks) |
| cfg_saved | input | 8 | New saved priority |
| rej_valid | input | 1 | Reject notification strobe |
| rej_num | input | NUM_W | Global number of the rejected source |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number of the finished source |
| resend_req | input | 1 | Resend broadcast strobe |
| req_valid | output | 1 | A request is presented this cycle |
| req_server | output | SRV_W | Target server of the request |
| req_num | output | NUM_W | Global source number of the request |
| req_prio | output | 8 | Priority of the request |

## Verification
Edge-style sources are driven masked, unmasked and after rejection, so that masked-pending release, a plain edge and a rejected retry are each told apart from a resend that must stay silent. Level-style sources are held asserted across resends, end-of-interrupt and reject, which separates the sent flag being kept from it being cleared. Three edges landing in one cycle show the ascending issue order, out-of-range reject and end numbers show that only this bank's range is decoded, and a reset in the middle of a masked-pending state shows the flags are wiped.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int PRIO_W = 8;
    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t PRIO_MASKED = 8'hFF;

    typedef struct packed {
        logic mpend;   // edge fired while masked
        logic rej;     // edge request was turned away
        logic asrt;    // level line currently high
        logic sent;    // level request outstanding
    } src_flags_t;
endpackage

// File: rtl/isc_src_cell.sv
module isc_src_cell
    import isc_pkg::*;
#(
    parameter int SRV_W    = 8,
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq,
    input  logic             cfg_hit,
    input  logic [SRV_W-1:0] cfg_srv,
    input  prio_t            cfg_prio,
    input  prio_t            cfg_saved,
    input  logic             rej_hit,
    input  logic             eoi_hit,
    input  logic             scan_hit,
    input  logic             grant,
    output logic             want,
    output logic [SRV_W-1:0] srv,
    output prio_t            prio
);
    typedef struct packed {
        logic [SRV_W-1:0] srv;
        prio_t            prio;
        prio_t            saved;
        src_flags_t       fl;
        logic             want;
        logic             prev;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        logic unmasked;
        logic new_want;
        logic lvl_chg;
        st_d     = st_q;
        new_want = 1'b0;
        lvl_chg  = 1'b0;
        st_d.prev = irq;
        if (cfg_hit) begin
            st_d.srv   = cfg_srv;
            st_d.prio  = cfg_prio;
            st_d.saved = cfg_saved;
        end
        unmasked = (st_d.prio != PRIO_MASKED);
        if (IS_LEVEL) begin
            lvl_chg      = (irq != st_q.fl.asrt);
            st_d.fl.asrt = irq;
            if (rej_hit || eoi_hit) begin
                st_d.fl.sent = 1'b0;
            end
            if ((lvl_chg || cfg_hit || scan_hit) && unmasked &&
                st_d.fl.asrt && !st_d.fl.sent) begin
                st_d.fl.sent = 1'b1;
                new_want     = 1'b1;
            end
        end else begin
            if (rej_hit) begin
                st_d.fl.rej = 1'b1;
            end
            if (irq && !st_q.prev) begin
                if (unmasked) begin
                    new_want = 1'b1;
                end else begin
                    st_d.fl.mpend = 1'b1;
                end
            end
            if (cfg_hit && st_d.fl.mpend && unmasked) begin
                st_d.fl.mpend = 1'b0;
                new_want      = 1'b1;
            end
            if (scan_hit && st_d.fl.rej) begin
                st_d.fl.rej = 1'b0;
                if (unmasked) begin
                    new_want = 1'b1;
                end
            end
        end
        st_d.want = (st_q.want & ~grant) | new_want;
        // a queued request whose source became masked is parked again
        if (st_d.want && !unmasked) begin
            st_d.want = 1'b0;
            if (IS_LEVEL) begin
                st_d.fl.sent = 1'b0;
            end else begin
                st_d.fl.mpend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.srv   <= '0;
            st_q.prio  <= PRIO_MASKED;
            st_q.saved <= PRIO_MASKED;
            st_q.fl    <= '0;
            st_q.want  <= 1'b0;
            st_q.prev  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign want = st_q.want;
    assign srv  = st_q.srv;
    assign prio = st_q.prio;

    // R11: saved priority moves only on a configuration write
    p_saved_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hit |=> $stable(st_q.saved));

    generate
        if (IS_LEVEL) begin : g_lvl_chk
            // R5: a reject leaves a level source not sent
            p_lvl_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (rej_hit && !scan_hit && !cfg_hit && irq == st_q.fl.asrt) |=> !st_q.fl.sent);
            // R1: level sources never carry edge-only flags
            p_lvl_no_edge_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
                !st_q.fl.mpend && !st_q.fl.rej);
        end else begin : g_edge_chk
            // R5: a reject is recorded on an edge source
            p_edge_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (rej_hit && !scan_hit) |=> st_q.fl.rej);
            // R7: edge sources never carry level-only flags
            p_edge_no_lvl_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !st_q.fl.sent && !st_q.fl.asrt);
        end
    endgenerate
endmodule

// File: rtl/isc_scan.sv
module isc_scan #(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             resend_req,
    output logic             scan_valid,
    output logic [IDX_W-1:0] scan_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

    typedef struct packed {
        logic             act;
        logic [IDX_W-1:0] idx;
    } scan_t;

    scan_t sc_d, sc_q;

    always_comb begin
        sc_d = sc_q;
        if (resend_req) begin
            sc_d.act = 1'b1;
            sc_d.idx = '0;
        end else if (sc_q.act) begin
            if (sc_q.idx == LAST) begin
                sc_d.act = 1'b0;
                sc_d.idx = '0;
            end else begin
                sc_d.idx = sc_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    assign scan_valid = sc_q.act;
    assign scan_idx   = sc_q.idx;

    // R6: the scan pointer stays inside the bank
    p_scan_in_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid |-> (int'(scan_idx) < NUM_SRC));
endmodule

// File: rtl/isc_arbiter.sv
module isc_arbiter
    import isc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int SRV_W   = 8,
    parameter int NUM_W   = 16,
    parameter int BASE    = 'h1000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            want,
    input  logic [NUM_SRC-1:0][SRV_W-1:0] srv_all,
    input  prio_t [NUM_SRC-1:0]           prio_all,
    output logic [NUM_SRC-1:0]            grant,
    output logic                          req_valid,
    output logic [SRV_W-1:0]              req_server,
    output logic [NUM_W-1:0]              req_num,
    output prio_t                         req_prio
);
    localparam logic [NUM_W-1:0] BASE_V = NUM_W'(BASE);

    typedef struct packed {
        logic             valid;
        logic [SRV_W-1:0] srv;
        logic [NUM_W-1:0] num;
        prio_t            prio;
    } req_t;

    req_t rq_d, rq_q;

    always_comb begin
        int sel;
        sel   = 0;
        grant = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (want[i]) sel = i;
        end
        rq_d = '0;
        if (|want) begin
            grant[sel] = 1'b1;
            rq_d.valid = 1'b1;
            rq_d.srv   = srv_all[sel];
            rq_d.num   = BASE_V + NUM_W'(sel);
            rq_d.prio  = prio_all[sel];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_q <= '0;
        end else begin
            rq_q <= rq_d;
        end
    end

    assign req_valid  = rq_q.valid;
    assign req_server = rq_q.srv;
    assign req_num    = rq_q.num;
    assign req_prio   = rq_q.prio;

    // R9: at most one grant, and no lower-index source left waiting
    p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_lowest_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((want & (grant - 1'b1)) == '0));
endmodule

// File: rtl/intr_source_ctl.sv
module intr_source_ctl
    import isc_pkg::*;
#(
    parameter int NUM_SRC            = 16,
    parameter int SRV_W              = 8,
    parameter int NUM_W              = 16,
    parameter int BASE               = 'h1000,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 16'hFF00,
    localparam int IDX_W             = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [7:0]         cfg_prio,
    input  logic [7:0]         cfg_saved,
    input  logic               rej_valid,
    input  logic [NUM_W-1:0]   rej_num,
    input  logic               eoi_valid,
    input  logic [NUM_W-1:0]   eoi_num,
    input  logic               resend_req,
    output logic               req_valid,
    output logic [SRV_W-1:0]   req_server,
    output logic [NUM_W-1:0]   req_num,
    output logic [7:0]         req_prio
);
    localparam logic [NUM_W-1:0] BASE_V = NUM_W'(BASE);
    localparam logic [NUM_W-1:0] CNT_V  = NUM_W'(NUM_SRC);

    logic [NUM_W-1:0]            rej_off, eoi_off;
    logic                        rej_in, eoi_in;
    logic                        scan_valid;
    logic [IDX_W-1:0]            scan_idx;
    logic [NUM_SRC-1:0]          want, grant;
    logic [NUM_SRC-1:0]          cfg_hit, rej_hit, eoi_hit, scan_hit;
    logic [NUM_SRC-1:0][SRV_W-1:0] srv_all;
    prio_t [NUM_SRC-1:0]         prio_all;

    // R8: only numbers inside this bank's window are decoded
    always_comb begin
        rej_off = rej_num - BASE_V;
        eoi_off = eoi_num - BASE_V;
        rej_in  = rej_valid && (rej_num >= BASE_V) && (rej_off < CNT_V);
        eoi_in  = eoi_valid && (eoi_num >= BASE_V) && (eoi_off < CNT_V);
        for (int i = 0; i < NUM_SRC; i++) begin
            cfg_hit[i]  = cfg_we && (cfg_idx == IDX_W'(i));
            rej_hit[i]  = rej_in && (rej_off == NUM_W'(i));
            eoi_hit[i]  = eoi_in && (eoi_off == NUM_W'(i));
            scan_hit[i] = scan_valid && (scan_idx == IDX_W'(i));
        end
    end

    isc_scan #(.NUM_SRC(NUM_SRC)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .resend_req (resend_req),
        .scan_valid (scan_valid),
        .scan_idx   (scan_idx)
    );

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            isc_src_cell #(
                .SRV_W    (SRV_W),
                .IS_LEVEL (LEVEL_MASK[g])
            ) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .irq       (irq_in[g]),
                .cfg_hit   (cfg_hit[g]),
                .cfg_srv   (cfg_server),
                .cfg_prio  (cfg_prio),
                .cfg_saved (cfg_saved),
                .rej_hit   (rej_hit[g]),
                .eoi_hit   (eoi_hit[g]),
                .scan_hit  (scan_hit[g]),
                .grant     (grant[g]),
                .want      (want[g]),
                .srv       (srv_all[g]),
                .prio      (prio_all[g])
            );
        end
    endgenerate

    isc_arbiter #(
        .NUM_SRC (NUM_SRC),
        .SRV_W   (SRV_W),
        .NUM_W   (NUM_W),
        .BASE    (BASE)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .want       (want),
        .srv_all    (srv_all),
        .prio_all   (prio_all),
        .grant      (grant),
        .req_valid  (req_valid),
        .req_server (req_server),
        .req_num    (req_num),
        .req_prio   (req_prio)
    );

    // R1: a request never carries the masking priority
    p_no_masked_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_prio != PRIO_MASKED));
    // R2: every request number lies in this bank's window
    p_num_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_num >= BASE_V) && (req_num - BASE_V < CNT_V));
    // R10: nothing is presented in the cycle after reset
    p_quiet_after_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !req_valid);
endmodule

// File: tb/tb_intr_source_ctl.sv
module tb_intr_source_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_server = '0;
    logic [7:0]  cfg_prio = '0;
    logic [7:0]  cfg_saved = '0;
    logic        rej_valid = 1'b0;
    logic [15:0] rej_num = '0;
    logic        eoi_valid = 1'b0;
    logic [15:0] eoi_num = '0;
    logic        resend_req = 1'b0;
    logic        req_valid;
    logic [7:0]  req_server;
    logic [15:0] req_num;
    logic [7:0]  req_prio;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R10";
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_source_ctl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
        .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
        .rej_valid(rej_valid), .rej_num(rej_num),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend_req(resend_req),
        .req_valid(req_valid), .req_server(req_server),
        .req_num(req_num), .req_prio(req_prio)
    );

    // monitor: pops the scoreboard whenever a request appears
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL %s unexpected request actual=%h/%h/%h expected=none",
                         cur_tag, req_server, req_num, req_prio);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({req_server, req_num, req_prio} !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t,
                             {req_server, req_num, req_prio}, e);
                end
            end
        end
    end

    task automatic expect_req(input logic [7:0] s, input logic [15:0] n,
                              input logic [7:0] p, input string t);
        exp_q.push_back({s, n, p});
        tag_q.push_back(t);
    endtask

    task automatic quiet(input string t);
        repeat (40) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL %s missing requests actual=0 expected=%0d", t, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg(input int i, input logic [7:0] s, input logic [7:0] p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(i); cfg_server = s; cfg_prio = p; cfg_saved = p;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk);
        irq_in = irq_in | m;
        @(negedge clk);
        irq_in = irq_in & ~m;
    endtask

    task automatic set_lvl(input int i, input logic v);
        @(negedge clk);
        irq_in[i] = v;
    endtask

    task automatic reject(input logic [15:0] n);
        @(negedge clk);
        rej_valid = 1'b1; rej_num = n;
        @(negedge clk);
        rej_valid = 1'b0;
    endtask

    task automatic eoi(input logic [15:0] n);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_num = n;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic resend();
        @(negedge clk);
        resend_req = 1'b1;
        @(negedge clk);
        resend_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R10: idle output after reset
        @(negedge clk);
        checks++;
        if (req_valid !== 1'b0) begin
            failures++;
            $display("FAIL R10 req_valid actual=%b expected=0", req_valid);
        end

        // R1: masked edge source stays silent, then R3 releases it
        cur_tag = "R1";
        pulse(16'h0001);
        quiet("R1");
        cur_tag = "R3";
        expect_req(8'd2, 16'h1000, 8'd5, "R3");
        cfg(0, 8'd2, 8'd5);
        quiet("R3");

        // R2: unmasked edge
        cur_tag = "R2";
        cfg(1, 8'd3, 8'd4);
        quiet("R2");
        expect_req(8'd3, 16'h1001, 8'd4, "R2");
        pulse(16'h0002);
        quiet("R2");

        // R9: three edges in one cycle
        cur_tag = "R9";
        cfg(2, 8'd5, 8'd6);
        cfg(3, 8'd6, 8'd7);
        expect_req(8'd3, 16'h1001, 8'd4, "R9");
        expect_req(8'd5, 16'h1002, 8'd6, "R9");
        expect_req(8'd6, 16'h1003, 8'd7, "R9");
        pulse(16'h000E);
        quiet("R9");

        // R5 / R6: rejected edge retried only on resend
        cur_tag = "R5";
        reject(16'h1001);
        quiet("R5");
        cur_tag = "R6";
        expect_req(8'd3, 16'h1001, 8'd4, "R6");
        resend();
        quiet("R6");
        resend();
        quiet("R6");

        // R7: end-of-interrupt on an edge source has no effect
        cur_tag = "R7";
        eoi(16'h1001);
        resend();
        quiet("R7");

        // R11 / R4: level source
        cur_tag = "R11";
        cfg(8, 8'd1, 8'd2);
        quiet("R11");
        cur_tag = "R4";
        expect_req(8'd1, 16'h1008, 8'd2, "R4");
        set_lvl(8, 1'b1);
        quiet("R4");
        resend();
        quiet("R4");

        // R7: end-of-interrupt re-arms the level source for resend
        cur_tag = "R7";
        eoi(16'h1008);
        quiet("R7");
        expect_req(8'd1, 16'h1008, 8'd2, "R7");
        resend();
        quiet("R7");

        // R8: out-of-window numbers ignored
        cur_tag = "R8";
        reject(16'h1010);
        reject(16'h0FF8);
        eoi(16'h1018);
        resend();
        quiet("R8");

        // R5: reject on level clears sent
        cur_tag = "R5";
        reject(16'h1008);
        expect_req(8'd1, 16'h1008, 8'd2, "R5");
        resend();
        quiet("R5");

        // R1 / R11: masked level waits for a configuration write
        cur_tag = "R1";
        set_lvl(9, 1'b1);
        quiet("R1");
        cur_tag = "R11";
        expect_req(8'd4, 16'h1009, 8'd3, "R11");
        cfg(9, 8'd4, 8'd3);
        quiet("R11");

        // R10: reset wipes masked-pending and priorities
        cur_tag = "R10";
        set_lvl(8, 1'b0);
        set_lvl(9, 1'b0);
        cfg(0, 8'd2, 8'hFF);
        pulse(16'h0001);
        quiet("R10");
        do_reset();
        cfg(0, 8'd2, 8'd5);
        pulse(16'h0002);
        quiet("R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule